// File: doc/BRIEF.md
# Fuse Command Controller with Security Lock

This block sequences commands for a bank of general-purpose fuse bits and one security fuse. Software hands it a command word over a valid/ready channel. The word holds a key, an argument and a command code. An accepted command keeps the controller busy for a fixed write latency. At the end of that latency the fuse change takes effect and a one-cycle done pulse is raised. Two sticky error flags report the outcome of the last accepted command: a programming error for a malformed command and a lock error for a command the security fuse refuses.

The lowest general-purpose fuse bits also serve as region lock bits. A region whose bit reads 0 is locked. After the security fuse has been set, it blocks erase-all and programming of fuse byte 2. Only a chip-erase request from the debug side can clear the security fuse. That request restores every fuse to the erased state of 1 and clears the security fuse in a single operation.

The command channel follows valid/ready rules. A word transfers on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low while a command or a chip erase is in progress, while a chip erase is pending, and in any cycle where `dbg_erase_req` is high. A sender that sees `cmd_ready` low must keep `cmd_valid` and `cmd_data` steady until the transfer happens.

Top module: `fuse_cmd_ctrl`

## Requirements
- R1: An accepted command holds `cmd_ready` low for exactly 4 cycles. `done` pulses for one cycle in the cycle after that, and `cmd_ready` returns high in that same cycle.
- R2: The command word is laid out as key = bits [31:24], argument = bits [23:6] and code = bits [5:0], and the key must be 0xA7. A wrong key, or a code outside 1..6, sets `err_prog` and leaves every fuse unchanged.
- R3: Code 1 (write bit) writes argument bit 8 into the fuse bit whose index is given by argument bits [7:0].
- R4: Code 2 (program byte) selects the fuse byte given by argument bits [2:0] and clears each of its bits where argument bits [10:3] hold 0. Bits where the value holds 1 keep their old state.
- R5: Code 3 (erase all) sets every general-purpose fuse bit to 1 when the security fuse is clear.
- R6: Code 4 (lock region) clears fuse bit n and code 5 (unlock region) sets fuse bit n, where n is argument bits [3:0] and only bits 15..0 can be addressed this way. `region_locked` is the inverse of fuse bits 15..0.
- R7: Code 6 sets the security fuse. No other command sets it, and no command other than chip erase clears it. Lock and unlock commands still work while it is set.
- R8: While the security fuse is set, programming byte 2 sets `err_lock` and changes nothing, while programming any other byte works normally.
- R9: While the security fuse is set, erase all sets `err_lock` and changes nothing.
- R10: A `dbg_erase_req` pulse sets all fuses to 1 and clears the security fuse. If a command is in progress, the erase waits for it to finish. At an idle cycle the erase is served before a command presented in the same cycle, and it leaves the error flags unchanged.
- R11: The error flags hold their value until the next accepted command, which replaces both of them.
- R12: A bit index of 32 or more, or a byte index of 4 or more, sets `err_prog` and changes nothing.
- R13: After reset all fuses read 1, the security fuse is clear, `cmd_ready` is high, and `done`, `err_prog` and `err_lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word is offered |
| cmd_ready | output | 1 | Controller can take a command word |
| cmd_data | input | 32 | Command word: key, argument, code |
| dbg_erase_req | input | 1 | Chip-erase request pulse from the debug side |
| done | output | 1 | One-cycle pulse when a command or erase finishes |
| err_prog | output | 1 | Sticky programming error |
| err_lock | output | 1 | Sticky lock error |
| fuse_q | output | 32 | Current general-purpose fuse bits |
| region_locked | output | 16 | One bit per region, 1 = locked |
| secure | output | 1 | Security fuse state |

## Verification
The hardest case to reach is a chip erase that collides with command traffic. This happens in two ways: the request arrives while a command is in flight and a second command is already waiting, or it arrives in the same idle cycle as a new command. The stimulus sets the security fuse first. It then offers a command, pulses the erase request during the busy window, and keeps the next command word valid throughout. This checks that the results appear in the order first command, erase, waiting command, and that the security fuse is clear afterwards. A second run raises the request and a command word together at an idle edge, where the erase must go first.

// File: rtl/fusectl_pkg.sv
package fusectl_pkg;
  localparam int CODE_W = 6;
  localparam int IDX_W  = 8;

  localparam logic [CODE_W-1:0] CODE_WBIT   = 6'd1;
  localparam logic [CODE_W-1:0] CODE_PBYTE  = 6'd2;
  localparam logic [CODE_W-1:0] CODE_ERASE  = 6'd3;
  localparam logic [CODE_W-1:0] CODE_LOCK   = 6'd4;
  localparam logic [CODE_W-1:0] CODE_UNLOCK = 6'd5;
  localparam logic [CODE_W-1:0] CODE_SECURE = 6'd6;

  typedef enum logic [2:0] {
    OP_NONE, OP_WBIT, OP_PBYTE, OP_ERASE, OP_LOCK, OP_UNLOCK, OP_SECURE, OP_CHIP
  } op_kind_e;

  typedef struct packed {
    op_kind_e         kind;
    logic [IDX_W-1:0] idx;
    logic [7:0]       val;
  } fuse_op_t;
endpackage

// File: rtl/fusectl_decode.sv
module fusectl_decode
  import fusectl_pkg::*;
#(
  parameter int             CMD_W  = 32,
  parameter int             KEY_W  = 8,
  parameter int             N_FUSE = 32,
  parameter int             N_LOCK = 16,
  parameter logic [KEY_W-1:0] KEY  = 8'hA7
) (
  input  logic [CMD_W-1:0] cmd,
  input  logic             secure,
  output fuse_op_t         op,
  output logic             bad_cmd,
  output logic             lock_hit
);
  localparam int ARG_W  = CMD_W - KEY_W - CODE_W;
  localparam int N_BYTE = N_FUSE / 8;
  localparam int LK_W   = $clog2(N_LOCK);

  logic [KEY_W-1:0]  key;
  logic [CODE_W-1:0] code;
  logic [ARG_W-1:0]  arg;
  logic              unused_arg_hi;

  assign key  = cmd[CMD_W-1 -: KEY_W];
  assign code = cmd[CODE_W-1:0];
  assign arg  = cmd[CODE_W +: ARG_W];
  assign unused_arg_hi = ^arg[ARG_W-1:11];

  always_comb begin
    op       = '0;
    bad_cmd  = 1'b0;
    lock_hit = 1'b0;
    if (key != KEY) begin
      bad_cmd = 1'b1;
    end else begin
      case (code)
        CODE_WBIT: begin
          if (32'(arg[7:0]) < N_FUSE) begin
            op.kind = OP_WBIT;
            op.idx  = arg[7:0];
            op.val  = {7'b0, arg[8]};
          end else begin
            bad_cmd = 1'b1;
          end
        end
        CODE_PBYTE: begin
          if (32'(arg[2:0]) >= N_BYTE) begin
            bad_cmd = 1'b1;
          end else if (secure && arg[2:0] == 3'd2) begin
            lock_hit = 1'b1;
          end else begin
            op.kind = OP_PBYTE;
            op.idx  = IDX_W'(arg[2:0]);
            op.val  = arg[10:3];
          end
        end
        CODE_ERASE: begin
          if (secure) lock_hit = 1'b1;
          else        op.kind  = OP_ERASE;
        end
        CODE_LOCK, CODE_UNLOCK: begin
          if (32'(arg[LK_W-1:0]) < N_LOCK) begin
            op.kind = (code == CODE_LOCK) ? OP_LOCK : OP_UNLOCK;
            op.idx  = IDX_W'(arg[LK_W-1:0]);
          end else begin
            bad_cmd = 1'b1;
          end
        end
        CODE_SECURE: op.kind = OP_SECURE;
        default:     bad_cmd = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fusectl_seq.sv
module fusectl_seq
  import fusectl_pkg::*;
#(
  parameter int WR_LAT = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  fuse_op_t cmd_op,
  input  logic     cmd_bad,
  input  logic     cmd_lock,
  input  logic     erase_req,
  output logic     cmd_ready,
  output logic     apply,
  output fuse_op_t apply_op,
  output logic     done,
  output logic     err_prog,
  output logic     err_lock
);
  localparam int CNT_W = $clog2(WR_LAT + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             erase_pend;
  fuse_op_t         held;
  logic             take_cmd;
  logic             take_erase;

  assign cmd_ready  = !busy && !erase_pend && !erase_req;
  assign take_erase = !busy && (erase_pend || erase_req);
  assign take_cmd   = cmd_valid && cmd_ready;
  assign apply      = busy && (cnt == CNT_W'(1));
  assign apply_op   = held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      erase_pend <= 1'b0;
      held       <= '0;
      done       <= 1'b0;
      err_prog   <= 1'b0;
      err_lock   <= 1'b0;
    end else begin
      done <= apply;
      if (take_erase)     erase_pend <= 1'b0;
      else if (erase_req) erase_pend <= 1'b1;

      if (take_erase) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(WR_LAT);
        held <= '{kind: OP_CHIP, idx: '0, val: '0};
      end else if (take_cmd) begin
        busy     <= 1'b1;
        cnt      <= CNT_W'(WR_LAT);
        held     <= cmd_op;
        err_prog <= cmd_bad;
        err_lock <= cmd_lock;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) busy <= 1'b0;
      end
    end
  end

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_cmd |=> $stable({err_prog, err_lock}));
  // R10
  erase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !busy) |=> (busy && held.kind == OP_CHIP));
endmodule

// File: rtl/fusectl_bank.sv
module fusectl_bank
  import fusectl_pkg::*;
#(
  parameter int N_FUSE = 32,
  parameter int N_LOCK = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  fuse_op_t          op,
  output logic [N_FUSE-1:0] fuse_q,
  output logic              secure
);
  localparam int N_BYTE = N_FUSE / 8;

  logic [N_FUSE-1:0] nxt;
  logic              sec_nxt;

  always_comb begin
    nxt     = fuse_q;
    sec_nxt = secure;
    case (op.kind)
      OP_WBIT:
        for (int i = 0; i < N_FUSE; i++)
          if (op.idx == IDX_W'(i)) nxt[i] = op.val[0];
      OP_PBYTE:
        for (int b = 0; b < N_BYTE; b++)
          if (op.idx == IDX_W'(b)) nxt[b*8 +: 8] = fuse_q[b*8 +: 8] & op.val;
      OP_ERASE: nxt = '1;
      OP_LOCK:
        for (int i = 0; i < N_LOCK; i++)
          if (op.idx == IDX_W'(i)) nxt[i] = 1'b0;
      OP_UNLOCK:
        for (int i = 0; i < N_LOCK; i++)
          if (op.idx == IDX_W'(i)) nxt[i] = 1'b1;
      OP_SECURE: sec_nxt = 1'b1;
      OP_CHIP: begin
        nxt     = '1;
        sec_nxt = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fuse_q <= '1;
      secure <= 1'b0;
    end else if (apply) begin
      fuse_q <= nxt;
      secure <= sec_nxt;
    end
  end

  // R7
  sec_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secure) |-> $past(apply && op.kind == OP_SECURE));
  // R10
  sec_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secure) |-> $past(apply && op.kind == OP_CHIP));
  // R2
  fuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(fuse_q));
  // R5
  erase_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && op.kind == OP_ERASE) |=> (&fuse_q));
endmodule

// File: rtl/fuse_cmd_ctrl.sv
module fuse_cmd_ctrl
  import fusectl_pkg::*;
#(
  parameter int               CMD_W  = 32,
  parameter int               KEY_W  = 8,
  parameter int               N_FUSE = 32,
  parameter int               N_LOCK = 16,
  parameter int               WR_LAT = 4,
  parameter logic [KEY_W-1:0] KEY    = 8'hA7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              dbg_erase_req,
  output logic              done,
  output logic              err_prog,
  output logic              err_lock,
  output logic [N_FUSE-1:0] fuse_q,
  output logic [N_LOCK-1:0] region_locked,
  output logic              secure
);
  fuse_op_t dec_op;
  fuse_op_t apply_op;
  logic     dec_bad;
  logic     dec_lock;
  logic     apply;

  fusectl_decode #(
    .CMD_W(CMD_W), .KEY_W(KEY_W), .N_FUSE(N_FUSE), .N_LOCK(N_LOCK), .KEY(KEY)
  ) u_decode (
    .cmd(cmd_data), .secure(secure), .op(dec_op), .bad_cmd(dec_bad), .lock_hit(dec_lock)
  );

  fusectl_seq #(.WR_LAT(WR_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(dec_op),
    .cmd_bad(dec_bad), .cmd_lock(dec_lock), .erase_req(dbg_erase_req),
    .cmd_ready(cmd_ready), .apply(apply), .apply_op(apply_op), .done(done),
    .err_prog(err_prog), .err_lock(err_lock)
  );

  fusectl_bank #(.N_FUSE(N_FUSE), .N_LOCK(N_LOCK)) u_bank (
    .clk(clk), .rst_n(rst_n), .apply(apply), .op(apply_op),
    .fuse_q(fuse_q), .secure(secure)
  );

  assign region_locked = ~fuse_q[N_LOCK-1:0];

  // R6
  lock_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && apply_op.kind == OP_LOCK) |=> (region_locked != '0));
endmodule

// File: tb/test_fuse_cmd_ctrl.sv
`timescale 1ns/1ps
module test_fuse_cmd_ctrl;
  localparam logic [7:0] KEY = 8'hA7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = '0;
  logic        dbg_erase_req = 1'b0;
  logic        done, err_prog, err_lock, secure;
  logic [31:0] fuse_q;
  logic [15:0] region_locked;

  always #4 clk = ~clk;

  fuse_cmd_ctrl i_fuse_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .dbg_erase_req(dbg_erase_req), .done(done),
    .err_prog(err_prog), .err_lock(err_lock), .fuse_q(fuse_q),
    .region_locked(region_locked), .secure(secure)
  );

  typedef struct {
    logic [31:0] fuse;
    logic        sec;
    logic        ep;
    logic        el;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] m_fuse = '1;
  logic        m_sec = 1'b0, m_ep = 1'b0, m_el = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] key, input logic [17:0] arg,
                                     input logic [5:0] code);
    return {key, arg, code};
  endfunction

  // Expected effect of one accepted command word, per the requirements
  task automatic predict(input string req, input logic [31:0] w);
    logic [17:0] a;
    logic [5:0]  c;
    exp_t        e;
    a = w[23:6];
    c = w[5:0];
    m_ep = 1'b0;
    m_el = 1'b0;
    if (w[31:24] != KEY) m_ep = 1'b1;
    else case (c)
      6'd1: if (a[7:0] < 8'd32) m_fuse[a[4:0]] = a[8]; else m_ep = 1'b1;
      6'd2: if (a[2:0] >= 3'd4) m_ep = 1'b1;
            else if (m_sec && a[2:0] == 3'd2) m_el = 1'b1;
            else m_fuse[a[1:0]*8 +: 8] = m_fuse[a[1:0]*8 +: 8] & a[10:3];
      6'd3: if (m_sec) m_el = 1'b1; else m_fuse = '1;
      6'd4: m_fuse[a[3:0]] = 1'b0;
      6'd5: m_fuse[a[3:0]] = 1'b1;
      6'd6: m_sec = 1'b1;
      default: m_ep = 1'b1;
    endcase
    e.fuse = m_fuse; e.sec = m_sec; e.ep = m_ep; e.el = m_el; e.req = req;
    sb.push_back(e);
  endtask

  task automatic predict_chip(input string req);
    exp_t e;
    m_fuse = '1;
    m_sec  = 1'b0;
    e.fuse = m_fuse; e.sec = m_sec; e.ep = m_ep; e.el = m_el; e.req = req;
    sb.push_back(e);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Driver: push the expectation, hand over the word, check the R1 timing
  task automatic send(input string req, input logic [31:0] w);
    bit ok;
    predict(req, w);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    @(posedge clk);
    ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) cmd_valid = 1'b0;
      if (cmd_ready || done) ok = 1'b0;
    end
    @(negedge clk);
    chk(ok && done && cmd_ready, "R1", "busy window / done timing",
        {62'd0, done, cmd_ready}, 64'd3);
    drain();
  endtask

  // Monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1", "done with nothing expected", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(fuse_q == e.fuse, e.req, "fuse_q", 64'(fuse_q), 64'(e.fuse));
        chk(secure == e.sec, e.req, "secure", 64'(secure), 64'(e.sec));
        chk({err_prog, err_lock} == {e.ep, e.el}, e.req, "err_prog/err_lock",
            64'({err_prog, err_lock}), 64'({e.ep, e.el}));
        chk(region_locked == ~e.fuse[15:0], "R6", "region_locked",
            64'(region_locked), 64'(~e.fuse[15:0]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fuse_q == '1 && !secure && cmd_ready && !done && !err_prog && !err_lock,
        "R13", "reset state",
        {25'd0, fuse_q, secure, cmd_ready, done, err_prog, err_lock, 2'd0},
        {25'd0, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0});

    send("R3", mk(KEY, 18'd20, 6'd1));
    send("R3", mk(KEY, 18'h100 | 18'd20, 6'd1));
    send("R3", mk(KEY, 18'd31, 6'd1));
    send("R4", mk(KEY, (18'h5A << 3) | 18'd1, 6'd2));
    send("R4", mk(KEY, (18'h0F << 3) | 18'd1, 6'd2));
    send("R4", mk(KEY, 18'd3, 6'd2));
    send("R6", mk(KEY, 18'd5, 6'd4));
    send("R6", mk(KEY, 18'd0, 6'd4));
    send("R6", mk(KEY, 18'd5, 6'd5));
    send("R2", mk(8'h3C, 18'd7, 6'd1));
    send("R11", mk(KEY, 18'd8, 6'd4));
    send("R2", mk(KEY, 18'd9, 6'h3F));
    send("R2", mk(KEY, 18'd9, 6'd0));
    send("R12", mk(KEY, 18'd40, 6'd1));
    send("R12", mk(KEY, (18'h00 << 3) | 18'd4, 6'd2));
    send("R5", mk(KEY, 18'd0, 6'd3));
    send("R4", mk(KEY, (18'h00 << 3) | 18'd2, 6'd2));
    send("R7", mk(KEY, 18'd0, 6'd6));
    send("R7", mk(KEY, 18'd3, 6'd4));
    send("R8", mk(KEY, (18'h00 << 3) | 18'd2, 6'd2));
    send("R11", mk(KEY, 18'd12, 6'd1));
    send("R8", mk(KEY, (18'hF0 << 3) | 18'd0, 6'd2));
    send("R9", mk(KEY, 18'd0, 6'd3));
    send("R7", mk(KEY, 18'd3, 6'd5));

    // R10: erase arrives during a busy command, next word already waiting
    predict("R10", mk(KEY, 18'd1, 6'd4));
    predict_chip("R10");
    predict("R10", mk(KEY, 18'd2, 6'd4));
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = mk(KEY, 18'd1, 6'd4);
    @(posedge clk);
    @(negedge clk);
    cmd_data      = mk(KEY, 18'd2, 6'd4);
    dbg_erase_req = 1'b1;
    @(negedge clk);
    dbg_erase_req = 1'b0;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    drain();

    // R10: erase and a command word presented at the same idle edge
    send("R7", mk(KEY, 18'd0, 6'd6));
    predict_chip("R10");
    predict("R10", mk(KEY, (18'h3C << 3) | 18'd2, 6'd2));
    @(negedge clk);
    cmd_valid     = 1'b1;
    cmd_data      = mk(KEY, (18'h3C << 3) | 18'd2, 6'd2);
    dbg_erase_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dbg_erase_req = 1'b0;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    drain();

    repeat (3) @(negedge clk);
    chk(sb.size() == 0 && cmd_ready && !done, "R1", "idle at end",
        64'(sb.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule